// File: doc/BRIEF.md
# SPI Serial Flash Device Model

This block behaves as a small serial flash memory on an SPI bus. A host selects it with an active-low chip select and shifts in an 8-bit opcode. Depending on the opcode, three address bytes and a data byte may follow on the serial input. The block holds a byte array. It can read the array as a stream, program single bytes, erase aligned sectors or blocks or the whole array, and report a status byte and a two-byte identity. Both idle clock polarities work: mode 0, with the clock idling low, and mode 3, with the clock idling high. Input bits are taken on clock rises and output bits change on clock falls.

All SPI pins are sampled by a fast system clock, so the whole design runs in one clock domain. A write-class command does nothing until chip select rises at the end of its frame. It also needs a write-enable latch that an earlier frame has set. When it is accepted, it runs as a timed job whose length is set by parameters, and the status busy bit stays high until the job ends. Two status bits choose how much of the top of the array is protected. Writes that land in the protected area are dropped.

Top module: `spiflash_slave`

## Requirements
- R1: After reset the status byte reads 0x0C: busy (bit 0) = 0, write-enable latch WEL (bit 1) = 0, protect level PL (bits 3:2) = 11. Bits 7:4 always read 0.
- R2: Input bits are taken MSB first on SCK rises, and output bits change on SCK falls, MSB first. This works with SCK idling low (mode 0) and with SCK idling high (mode 3).
- R3: Opcode 03h with a 24-bit address streams array bytes from that address until deselect. The address counts upward and wraps at the top of the array. Only the low ADDR_W address bits are used.
- R4: Opcode 05h returns the live status byte, repeated until deselect. It is accepted while busy.
- R5: Opcode 06h sets WEL and opcode 04h clears it. Opcodes 02h, 20h, 52h and 60h are ignored when WEL is 0. When WEL is 1, any of them clears WEL at deselect.
- R6: Opcode 50h followed, in the very next frame, by opcode 01h and one data byte loads PL from data bits 3:2. An 01h frame that does not follow 50h directly is ignored.
- R7: PL 00 protects nothing. PL 01 protects the top quarter of the array, PL 10 the top half and PL 11 all of it. A program or erase that touches the protected area is dropped.
- R8: Opcode 02h with an address and one data byte writes that byte at deselect. Busy reads 1 from deselect until PROG_CYC cycles have passed.
- R9: Opcode 20h fills the aligned 2^SECT_W-byte sector that holds the address with FFh. Opcode 52h does the same for the aligned 2^BLK_W-byte block. Bytes outside that region keep their values.
- R10: Opcode 60h fills the whole array with FFh. It is ignored entirely when PL is not 00.
- R11: While busy, every opcode other than 05h is ignored, along with the rest of its frame.
- R12: Opcodes 90h and ABh with an address return BFh and 48h alternately until deselect. The stream starts with BFh when address bit 0 is 0 and with 48h when it is 1.
- R13: spi_so_oe is 0 whenever chip select is high or the frame is not in an output phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for spi_so; 0 means the pin floats |

## Verification
The hardest condition to reach from the ports is a second command arriving while a timed job is still running. The window lasts only PROG_CYC or ERASE_CYC cycles after a deselect, and a single bus byte takes close to a hundred system clocks. The bench therefore starts a chip erase, whose byte-by-byte fill stretches the busy window well past one frame. It then sends a status read and a write-enable inside that window, and checks that the write-enable left no trace once busy clears. A program job is likewise followed at once by a three-byte status read, so that every repeated status byte is taken while busy is still high.

// File: rtl/spiflash_pkg.sv
package spiflash_pkg;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SECT = 8'h20;
  localparam logic [7:0] OP_BLK  = 8'h52;
  localparam logic [7:0] OP_CHIP = 8'h60;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_EWSR = 8'h50;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_ID_A = 8'h90;
  localparam logic [7:0] OP_ID_B = 8'hAB;

  localparam logic [7:0] ID_MAKER  = 8'hBF;
  localparam logic [7:0] ID_DEVICE = 8'h48;

  typedef enum logic [1:0] {JOB_PROG, JOB_SECT, JOB_BLK, JOB_CHIP} job_e;
  typedef enum logic [2:0] {D_OP, D_ADDR, D_DATA, D_OUT, D_SKIP} dec_e;
  typedef enum logic [1:0] {SRC_MEM, SRC_STAT, SRC_ID} src_e;

  // last address of the aligned 2^lg region holding a
  function automatic logic [15:0] span_top(logic [15:0] a, int unsigned lg);
    return a | ((16'd1 << lg) - 16'd1);
  endfunction

  // first address of the aligned 2^lg region holding a
  function automatic logic [15:0] span_base(logic [15:0] a, int unsigned lg);
    return a & ~((16'd1 << lg) - 16'd1);
  endfunction

  // protection test: top quarter / half / all, by level
  function automatic logic guarded(logic [1:0] lvl, logic [15:0] a, int unsigned aw);
    logic [15:0] qv;
    qv = a >> (aw - 2);
    unique case (lvl)
      2'b00:   return 1'b0;
      2'b01:   return qv[1:0] == 2'b11;
      2'b10:   return qv[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/sfl_serdes.sv
module sfl_serdes (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  input  logic [7:0] tx_byte,
  input  logic       out_phase,
  output logic       sel,
  output logic       cs_rise,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       so,
  output logic       so_oe
);
  logic [2:0] sck_p;
  logic [2:0] cs_p;
  logic [1:0] si_p;
  logic [2:0] bit_cnt;
  logic [6:0] in_sh;
  logic [7:0] out_sh;
  logic       so_q;
  logic       sck_rise;
  logic       sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '1;
      si_p  <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      cs_p  <= {cs_p[1:0], cs_n};
      si_p  <= {si_p[0], si};
    end
  end

  assign sck_rise = sck_p[1] & ~sck_p[2];
  assign sck_fall = ~sck_p[1] & sck_p[2];
  assign sel      = ~cs_p[1];
  assign cs_rise  = cs_p[1] & ~cs_p[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      in_sh    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      out_sh   <= '0;
      so_q     <= 1'b0;
    end else if (!sel) begin
      bit_cnt  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sck_rise) begin
        in_sh   <= {in_sh[5:0], si_p[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_valid <= 1'b1;
          rx_data  <= {in_sh, si_p[1]};
        end
      end
      if (sck_fall) begin
        if (bit_cnt == 3'd0) begin
          so_q   <= tx_byte[7];
          out_sh <= {tx_byte[6:0], 1'b0};
        end else begin
          so_q   <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
        end
      end
    end
  end

  assign so    = so_q;
  assign so_oe = sel & out_phase;

  // R2
  rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R13
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_p[1] |-> !so_oe);
endmodule

// File: rtl/sfl_guard.sv
module sfl_guard #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic              ev_wren,
  input  logic              ev_wrdi,
  input  logic              ev_ewsr,
  input  logic              ev_wrsr,
  input  logic [1:0]        new_lvl,
  input  logic              ev_consume,
  input  logic              busy,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic              any_guard,
  output logic              wel,
  output logic [7:0]        status
);
  import spiflash_pkg::*;

  logic [1:0] lvl_q;
  logic       wel_q;
  logic       arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 2'b11;
      wel_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (frame_end) arm_q <= ev_ewsr;
      if (ev_wrsr && arm_q) lvl_q <= new_lvl;
      if (ev_wren) wel_q <= 1'b1;
      else if (ev_wrdi || ev_consume) wel_q <= 1'b0;
    end
  end

  assign probe_hit = guarded(lvl_q, 16'(probe_addr), ADDR_W);
  assign any_guard = lvl_q != 2'b00;
  assign wel       = wel_q;
  assign status    = {4'b0000, lvl_q, wel_q, busy};

  // R6
  lvl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(ev_wrsr && arm_q));

  // R5
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(ev_wren));
endmodule

// File: rtl/sfl_array.sv
module sfl_array #(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned SECT_W    = 8,
  parameter int unsigned BLK_W     = 10,
  parameter int unsigned PROG_CYC  = 400,
  parameter int unsigned ERASE_CYC = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  spiflash_pkg::job_e job,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [7:0]        job_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);
  import spiflash_pkg::*;

  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned CYC_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned TW      = $clog2(CYC_MAX + 1);

  typedef enum logic [1:0] {A_IDLE, A_WIPE, A_WAIT} arr_e;

  logic [7:0]        mem [DEPTH];
  arr_e              st;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W:0]   left;
  logic [TW-1:0]     timer;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [7:0]        wdat;
  logic              prog_now;

  assign prog_now = (st == A_IDLE) && start && (job == JOB_PROG);
  assign we       = prog_now || (st == A_WIPE);
  assign waddr    = (st == A_WIPE) ? ptr : job_addr;
  assign wdat     = (st == A_WIPE) ? 8'hFF : job_data;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdat;
  end

  assign rd_data = mem[rd_addr];
  assign busy    = st != A_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= A_IDLE;
      ptr   <= '0;
      left  <= '0;
      timer <= '0;
    end else begin
      unique case (st)
        A_IDLE: if (start) begin
          unique case (job)
            JOB_PROG: begin
              timer <= TW'(PROG_CYC);
              st    <= A_WAIT;
            end
            JOB_SECT: begin
              ptr   <= ADDR_W'(span_base(16'(job_addr), SECT_W));
              left  <= (ADDR_W+1)'(1) << SECT_W;
              timer <= TW'(ERASE_CYC);
              st    <= A_WIPE;
            end
            JOB_BLK: begin
              ptr   <= ADDR_W'(span_base(16'(job_addr), BLK_W));
              left  <= (ADDR_W+1)'(1) << BLK_W;
              timer <= TW'(ERASE_CYC);
              st    <= A_WIPE;
            end
            default: begin
              ptr   <= '0;
              left  <= (ADDR_W+1)'(DEPTH);
              timer <= TW'(ERASE_CYC);
              st    <= A_WIPE;
            end
          endcase
        end
        A_WIPE: begin
          ptr  <= ptr + 1'b1;
          left <= left - 1'b1;
          if (left == (ADDR_W+1)'(1)) st <= A_WAIT;
        end
        default: begin
          if (timer == '0) st <= A_IDLE;
          else timer <= timer - 1'b1;
        end
      endcase
    end
  end

  // R11
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st == A_IDLE));

  // R8
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/spiflash_slave.sv
module spiflash_slave #(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned SECT_W    = 8,
  parameter int unsigned BLK_W     = 10,
  parameter int unsigned PROG_CYC  = 400,
  parameter int unsigned ERASE_CYC = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_si,
  output logic spi_so,
  output logic spi_so_oe
);
  import spiflash_pkg::*;

  logic              sel, cs_rise, rx_valid;
  logic [7:0]        rx_data;
  logic [7:0]        tx_q;
  logic              out_en_q;
  dec_e              st;
  src_e              src;
  logic [7:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [1:0]        acnt;
  logic              pend_q;
  logic              load_q;
  logic              id_q;
  logic [7:0]        rd_data;
  logic              busy;
  logic              wel;
  logic              probe_hit, any_guard;
  logic [7:0]        status;
  logic [ADDR_W-1:0] probe_addr;
  logic              is_write, blocked, eng_start, consume;
  job_e              job;

  sfl_serdes u_serdes (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si),
    .tx_byte(tx_q), .out_phase(out_en_q), .sel(sel), .cs_rise(cs_rise),
    .rx_valid(rx_valid), .rx_data(rx_data), .so(spi_so), .so_oe(spi_so_oe)
  );

  // decode of the finished frame
  logic done_ok;
  assign done_ok  = cs_rise && pend_q;
  assign is_write = (op_q == OP_PROG) || (op_q == OP_SECT) ||
                    (op_q == OP_BLK)  || (op_q == OP_CHIP);

  always_comb begin
    unique case (op_q)
      OP_SECT: begin job = JOB_SECT; probe_addr = ADDR_W'(span_top(16'(addr_q), SECT_W)); end
      OP_BLK:  begin job = JOB_BLK;  probe_addr = ADDR_W'(span_top(16'(addr_q), BLK_W));  end
      OP_CHIP: begin job = JOB_CHIP; probe_addr = addr_q; end
      default: begin job = JOB_PROG; probe_addr = addr_q; end
    endcase
  end

  assign blocked   = (op_q == OP_CHIP) ? any_guard : probe_hit;
  assign consume   = done_ok && is_write && wel;
  assign eng_start = consume && !blocked;

  sfl_guard #(.ADDR_W(ADDR_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .frame_end(cs_rise),
    .ev_wren(done_ok && op_q == OP_WREN),
    .ev_wrdi(done_ok && op_q == OP_WRDI),
    .ev_ewsr(done_ok && op_q == OP_EWSR),
    .ev_wrsr(done_ok && op_q == OP_WRSR),
    .new_lvl(data_q[3:2]), .ev_consume(consume), .busy(busy),
    .probe_addr(probe_addr), .probe_hit(probe_hit), .any_guard(any_guard),
    .wel(wel), .status(status)
  );

  sfl_array #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .job(job),
    .job_addr(addr_q), .job_data(data_q), .rd_addr(addr_q),
    .rd_data(rd_data), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= D_OP;
      src      <= SRC_STAT;
      op_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      acnt     <= '0;
      pend_q   <= 1'b0;
      load_q   <= 1'b0;
      out_en_q <= 1'b0;
      id_q     <= 1'b0;
      tx_q     <= '0;
    end else begin
      load_q <= 1'b0;
      if (cs_rise || !sel) begin
        st       <= D_OP;
        pend_q   <= 1'b0;
        out_en_q <= 1'b0;
        acnt     <= '0;
      end else if (rx_valid) begin
        unique case (st)
          D_OP: begin
            op_q <= rx_data;
            acnt <= '0;
            if (busy && rx_data != OP_RDSR) st <= D_SKIP;
            else begin
              unique case (rx_data)
                OP_READ, OP_PROG, OP_SECT, OP_BLK, OP_ID_A, OP_ID_B: st <= D_ADDR;
                OP_RDSR: begin
                  st <= D_OUT; src <= SRC_STAT; out_en_q <= 1'b1; load_q <= 1'b1;
                end
                OP_WREN, OP_WRDI, OP_EWSR, OP_CHIP: begin
                  pend_q <= 1'b1; st <= D_SKIP;
                end
                OP_WRSR: st <= D_DATA;
                default: st <= D_SKIP;
              endcase
            end
          end
          D_ADDR: begin
            addr_q <= ADDR_W'({addr_q, rx_data});
            acnt   <= acnt + 2'd1;
            if (acnt == 2'd2) begin
              unique case (op_q)
                OP_READ: begin
                  st <= D_OUT; src <= SRC_MEM; out_en_q <= 1'b1; load_q <= 1'b1;
                end
                OP_ID_A, OP_ID_B: begin
                  st <= D_OUT; src <= SRC_ID; id_q <= rx_data[0];
                  out_en_q <= 1'b1; load_q <= 1'b1;
                end
                OP_PROG: st <= D_DATA;
                default: begin pend_q <= 1'b1; st <= D_SKIP; end
              endcase
            end
          end
          D_DATA: begin
            data_q <= rx_data;
            pend_q <= 1'b1;
            st     <= D_SKIP;
          end
          D_OUT: load_q <= 1'b1;
          default: ;
        endcase
      end
      if (load_q) begin
        unique case (src)
          SRC_MEM: begin tx_q <= rd_data; addr_q <= addr_q + 1'b1; end
          SRC_ID:  begin tx_q <= id_q ? ID_DEVICE : ID_MAKER; id_q <= ~id_q; end
          default: tx_q <= status;
        endcase
      end
    end
  end

  // R5
  start_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> wel);

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !probe_hit || op_q == OP_CHIP);

  // R10
  chip_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && op_q == OP_CHIP) |-> !any_guard);
endmodule

// File: tb/spiflash_slave_tb.sv
module spiflash_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic so, so_oe;

  always #4 clk = ~clk;

  spiflash_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_si(si), .spi_so(so), .spi_so_oe(so_oe)
  );

  int checks = 0;
  int errors = 0;
  bit mode3 = 1'b0;
  logic [7:0] tx [12];
  logic [7:0] rx [12];

  // program table: {address, data}
  localparam logic [23:0] PVEC [6] = '{
    24'h0010_3C, 24'h0011_C3, 24'h0012_00, 24'h0013_FF, 24'h0014_81, 24'h0015_7E
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int n);
    @(negedge clk);
    cs_n = 1'b0;
    clks(6);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        sck = 1'b0;
        si = tx[i][b];
        clks(6);
        rx[i][b] = so;
        sck = 1'b1;
        clks(6);
      end
    end
    if (!mode3) sck = 1'b0;
    clks(6);
    cs_n = 1'b1;
    clks(10);
  endtask

  task automatic cmd(input logic [7:0] op);
    tx[0] = op;
    xfer(1);
  endtask

  task automatic rdsr(output logic [7:0] s);
    tx[0] = 8'h05; tx[1] = 8'h00;
    xfer(2);
    s = rx[1];
  endtask

  task automatic wait_idle;
    logic [7:0] s;
    for (int k = 0; k < 200; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic addr_cmd(input logic [7:0] op, input logic [15:0] a, input int extra);
    tx[0] = op; tx[1] = 8'h00; tx[2] = a[15:8]; tx[3] = a[7:0];
    for (int i = 4; i < 12; i++) tx[i] = 8'h00;
    xfer(4 + extra);
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d, input bit en);
    if (en) cmd(8'h06);
    tx[0] = 8'h02; tx[1] = 8'h00; tx[2] = a[15:8]; tx[3] = a[7:0]; tx[4] = d;
    xfer(5);
    wait_idle();
  endtask

  task automatic erase(input logic [7:0] op, input logic [15:0] a);
    cmd(8'h06);
    addr_cmd(op, a, 0);
    wait_idle();
  endtask

  task automatic rd1(input logic [15:0] a, output logic [7:0] d);
    addr_cmd(8'h03, a, 1);
    d = rx[4];
  endtask

  task automatic set_lvl(input logic [7:0] v);
    cmd(8'h50);
    tx[0] = 8'h01; tx[1] = v;
    xfer(2);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R0 watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] s, d;
    clks(5);
    rst_n = 1'b1;
    clks(5);

    // R13 idle output off, R1 reset status
    chk({7'd0, so_oe}, 8'h00, "R13 idle oe");
    rdsr(s); chk(s, 8'h0C, "R1 reset status");
    chk({7'd0, so_oe}, 8'h00, "R13 oe after frame");

    // R5 latch set and clear
    cmd(8'h06); rdsr(s); chk(s, 8'h0E, "R5 wren");
    cmd(8'h04); rdsr(s); chk(s, 8'h0C, "R5 wrdi");

    // R7 fully protected: program dropped, WEL cleared
    prog(16'h0040, 8'h99, 1'b1);
    rdsr(s); chk(s, 8'h0C, "R7 drop clears wel");

    // R6 level write after 50h; 01h alone ignored
    set_lvl(8'h00); rdsr(s); chk(s, 8'h00, "R6 level write");
    tx[0] = 8'h01; tx[1] = 8'h0C; xfer(2);
    rdsr(s); chk(s, 8'h00, "R6 unarmed write");

    // R10 chip erase, R11 ignored wren while busy, R4 status while busy
    cmd(8'h06); cmd(8'h60);
    rdsr(s); chk(s, 8'h01, "R10 chip erase busy");
    cmd(8'h06);
    wait_idle();
    rdsr(s); chk(s, 8'h00, "R11 wren while busy ignored");
    rd1(16'h0000, d); chk(d, 8'hFF, "R10 erased low");
    rd1(16'h07FF, d); chk(d, 8'hFF, "R10 erased top");

    // R5 program without latch ignored
    prog(16'h0020, 8'h11, 1'b0);
    rd1(16'h0020, d); chk(d, 8'hFF, "R5 no latch no write");

    // R8 table walk
    foreach (PVEC[i]) prog(PVEC[i][23:8], PVEC[i][7:0], 1'b1);
    foreach (PVEC[i]) begin
      rd1(PVEC[i][23:8], d); chk(d, PVEC[i][7:0], "R8 program readback");
    end
    // R3 burst read
    addr_cmd(8'h03, 16'h0010, 6);
    for (int i = 0; i < 6; i++) chk(rx[4+i], PVEC[i][7:0], "R3 stream");

    // R4 repeated status during a program job
    cmd(8'h06);
    tx[0] = 8'h02; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h30; tx[4] = 8'h44;
    xfer(5);
    tx[0] = 8'h05; tx[1] = 8'h00; tx[2] = 8'h00; xfer(3);
    chk(rx[1], 8'h01, "R4 status busy 1");
    chk(rx[2], 8'h01, "R4 status busy 2");
    wait_idle();
    rdsr(s); chk(s, 8'h00, "R8 busy clears");

    // R3 wrap at top of array
    prog(16'h07FF, 8'h5A, 1'b1);
    prog(16'h0000, 8'hA5, 1'b1);
    addr_cmd(8'h03, 16'h07FF, 2);
    chk(rx[4], 8'h5A, "R3 wrap top"); chk(rx[5], 8'hA5, "R3 wrap zero");

    // R9 sector and block erase
    prog(16'h0105, 8'h12, 1'b1);
    prog(16'h0205, 8'h34, 1'b1);
    erase(8'h20, 16'h01AB);
    rd1(16'h0105, d); chk(d, 8'hFF, "R9 sector cleared");
    rd1(16'h0205, d); chk(d, 8'h34, "R9 sector neighbour kept");
    erase(8'h52, 16'h03FF);
    rd1(16'h0205, d); chk(d, 8'hFF, "R9 block cleared");
    rd1(16'h0010, d); chk(d, 8'hFF, "R9 block base cleared");
    rd1(16'h07FF, d); chk(d, 8'h5A, "R9 outside block kept");

    // R7 top quarter guard, R10 chip erase refused
    set_lvl(8'h04); rdsr(s); chk(s, 8'h04, "R7 level one");
    prog(16'h0700, 8'h66, 1'b1);
    rdsr(s); chk(s, 8'h04, "R7 guarded drop wel");
    rd1(16'h0700, d); chk(d, 8'hFF, "R7 guarded unchanged");
    prog(16'h0500, 8'h77, 1'b1);
    rd1(16'h0500, d); chk(d, 8'h77, "R7 open region written");
    cmd(8'h06); cmd(8'h60);
    rdsr(s); chk(s, 8'h04, "R10 refused not busy");
    rd1(16'h0500, d); chk(d, 8'h77, "R10 refused data kept");

    // R12 identity stream
    addr_cmd(8'h90, 16'h0000, 3);
    chk(rx[4], 8'hBF, "R12 maker"); chk(rx[5], 8'h48, "R12 device");
    chk(rx[6], 8'hBF, "R12 repeat");
    addr_cmd(8'hAB, 16'h0001, 2);
    chk(rx[4], 8'h48, "R12 odd start"); chk(rx[5], 8'hBF, "R12 odd next");

    // R2 clock idling high
    mode3 = 1'b1; sck = 1'b1; clks(10);
    rd1(16'h0500, d); chk(d, 8'h77, "R2 mode3 read");
    rdsr(s); chk(s, 8'h04, "R2 mode3 status");
    mode3 = 1'b0; sck = 1'b0; clks(10);
    rd1(16'h07FF, d); chk(d, 8'h5A, "R2 mode0 read");
    chk({7'd0, so_oe}, 8'h00, "R13 final oe");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule